// File: doc/BRIEF.md
# Deep Sleep Entry Handshake Controller

This block decides when the platform may drop into a deep sleep level in which the primary power well is switched off. While the platform sits in one of the two deepest conventional sleep states, it checks a policy enable and the power source. If the battery-only policy is selected, it also requires that the platform is running on battery. The block then announces its intent to an external embedded controller by pulling an active-low warn line. Primary power is marked as removable only once the controller's acknowledge line has followed warn low.

On the way out, the primary-off indication is released first and warn is released afterwards. The block then waits for acknowledge to follow warn high again before it considers the handshake finished. Wake requests are edge-detected and held pending. A wake is accepted, with a one-cycle strobe, only where the two handshake wires agree and the battery is not reported low. A controller that takes no part in the handshake may tie acknowledge straight to warn, and the sequence still completes.

Top module: `pws_deep_sleep_ctrl`

## Requirements
- R1: While reset is asserted, warn_n and prim_off_n are high and wake_ok is low.
- R2: The platform is eligible for deep sleep only when policy_en is 1, sleep_state is 2'b10 (S4) or 2'b11 (S5), with 2'b00 meaning S0 and 2'b01 meaning S3, and batt_only is 0 or ac_present is 0. An ineligible platform never sees warn_n fall.
- R3: Eligibility must hold for ENTRY_HOLD consecutive clock edges. warn_n falls on the ENTRY_HOLD-th edge, and any ineligible cycle restarts the count.
- R4: prim_off_n falls only while warn_n is low, and only after the acknowledge input, taken through SYNC_STAGES synchronizer flops, reads low. With acknowledge tied to warn, prim_off_n falls SYNC_STAGES+1 edges after warn_n.
- R5: If eligibility is lost while the acknowledge is still awaited, warn_n returns high and prim_off_n never falls.
- R6: In deep sleep, an accepted wake or a loss of eligibility starts the exit. prim_off_n rises on the next edge, and warn_n rises one edge after prim_off_n.
- R7: After warn_n rises on exit, no entry and no wake acceptance take place until the synchronized acknowledge reads high. With acknowledge tied, the block is idle SYNC_STAGES+1 edges after warn_n rises.
- R8: While batt_low_n is 0, deep sleep is not left for a wake or a loss of eligibility, and no wake is accepted. Pending wakes are accepted once batt_low_n returns to 1.
- R9: Clearing policy_en forces an exit from deep sleep even while batt_low_n is 0. With policy_en at 0, warn_n and prim_off_n stay high.
- R10: A rising edge on the OR of the wake_req bits makes a wake pending. The wake is accepted with a one-cycle wake_ok pulse when the block is idle, or in deep sleep with the synchronized acknowledge low. When accepted at once, wake_ok is high after the second edge following the request.
- R11: A wake that arrives while warn_n is low and the acknowledge has not followed is held pending, not accepted, and is accepted after the acknowledge arrives.
- R12: In idle, a pending wake blocks entry and restarts the eligibility count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_state | input | 2 | Current sleep state: 00 S0, 01 S3, 10 S4, 11 S5 |
| ac_present | input | 1 | High while external power is connected |
| batt_low_n | input | 1 | Low while the battery cannot sustain an exit |
| policy_en | input | 1 | Deep sleep allowed at all |
| batt_only | input | 1 | Deep sleep only while running on battery |
| ack_n | input | 1 | Asynchronous acknowledge from the embedded controller |
| wake_req | input | NWAKE | Wake request levels |
| warn_n | output | 1 | Active-low intent to remove primary power |
| prim_off_n | output | 1 | Active-low primary-power-off indication |
| wake_ok | output | 1 | One-cycle strobe for an accepted wake |

## Verification
The bench builds the block with ENTRY_HOLD of 4, SYNC_STAGES of 2 and three wake inputs. These values keep every latency short enough to check on an exact edge. It sweeps all 32 combinations of policy enable, battery-only policy, power source and sleep state, and compares the entry decision against a formula. Both the tied-acknowledge case with zero latency and a manually delayed acknowledge are reachable. This brings into reach aborted entries, wakes parked behind an unmatched handshake, battery-low holds, forced exits and the restarted hold count after an idle wake.

// File: rtl/pws_pkg.sv
package pws_pkg;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_WARN,
    PS_DEEP,
    PS_RESTORE,
    PS_UNWARN
  } pws_state_e;

  localparam logic [1:0] SLP_S0 = 2'b00;
  localparam logic [1:0] SLP_S3 = 2'b01;
  localparam logic [1:0] SLP_S4 = 2'b10;
  localparam logic [1:0] SLP_S5 = 2'b11;

  function automatic logic deep_state_ok(input logic [1:0] st);
    return (st == SLP_S4) || (st == SLP_S5);
  endfunction

  function automatic logic power_src_ok(input logic batt_only, input logic ac_present);
    return !batt_only || !ac_present;
  endfunction

  function automatic logic entry_eligible(input logic policy_en, input logic [1:0] st,
                                          input logic batt_only, input logic ac_present);
    return policy_en && deep_state_ok(st) && power_src_ok(batt_only, ac_present);
  endfunction

  function automatic logic warn_active(input pws_state_e s);
    return (s == PS_WARN) || (s == PS_DEEP) || (s == PS_RESTORE);
  endfunction

  function automatic logic prim_off_active(input pws_state_e s);
    return s == PS_DEEP;
  endfunction

endpackage

// File: rtl/pws_sync.sv
module pws_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= {STAGES{RESET_VAL}};
        else        q <= {q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = q[STAGES-1];
endmodule

// File: rtl/pws_entry.sv
module pws_entry #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic elig,
  output logic go
);
  generate
    if (HOLD <= 1) begin : g_direct
      assign go = arm && elig;
    end else begin : g_count
      localparam int CW = $clog2(HOLD);
      localparam logic [CW-1:0] LAST = CW'(HOLD - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (!arm || !elig)  cnt <= '0;
        else if (cnt != LAST)    cnt <= cnt + 1'b1;
      end

      assign go = arm && elig && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/pws_wake.sv
module pws_wake #(
  parameter int NWAKE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NWAKE-1:0] wake_req,
  input  logic             open,
  output logic             pending,
  output logic             accept,
  output logic             wake_ok
);
  logic any_req, any_q, rise;

  assign any_req = |wake_req;
  assign rise    = any_req && !any_q;
  assign accept  = pending && open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_q   <= 1'b0;
      pending <= 1'b0;
      wake_ok <= 1'b0;
    end else begin
      any_q   <= any_req;
      pending <= (pending && !accept) || rise;
      wake_ok <= accept;
    end
  end
endmodule

// File: rtl/pws_fsm.sv
module pws_fsm
  import pws_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       elig,
  input  logic       policy_en,
  input  logic       batt_ok,
  input  logic       ack_low,
  input  logic       pending,
  output pws_state_e state,
  output logic       open,
  output logic       warn_n,
  output logic       prim_off_n
);
  pws_state_e nxt;

  assign open = batt_ok && ((state == PS_IDLE) || ((state == PS_DEEP) && ack_low));

  always_comb begin
    nxt = state;
    case (state)
      PS_IDLE:    if (go) nxt = PS_WARN;
      PS_WARN: begin
        if (!elig)        nxt = PS_UNWARN;
        else if (ack_low) nxt = PS_DEEP;
      end
      PS_DEEP: begin
        if (!policy_en)                                    nxt = PS_RESTORE;
        else if (batt_ok && ((pending && ack_low) || !elig)) nxt = PS_RESTORE;
      end
      PS_RESTORE: nxt = PS_UNWARN;
      PS_UNWARN:  if (!ack_low) nxt = PS_IDLE;
      default:    nxt = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_IDLE;
    else        state <= nxt;
  end

  assign warn_n     = !warn_active(state);
  assign prim_off_n = !prim_off_active(state);
endmodule

// File: rtl/pws_deep_sleep_ctrl.sv
module pws_deep_sleep_ctrl
  import pws_pkg::*;
#(
  parameter int NWAKE       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_HOLD  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sleep_state,
  input  logic             ac_present,
  input  logic             batt_low_n,
  input  logic             policy_en,
  input  logic             batt_only,
  input  logic             ack_n,
  input  logic [NWAKE-1:0] wake_req,
  output logic             warn_n,
  output logic             prim_off_n,
  output logic             wake_ok
);
  logic       ack_s;
  logic       ack_low;
  logic       elig;
  logic       arm;
  logic       go;
  logic       open;
  logic       pending;
  logic       accept;
  pws_state_e state;

  assign elig    = entry_eligible(policy_en, sleep_state, batt_only, ac_present);
  assign ack_low = !ack_s;
  assign arm     = (state == PS_IDLE) && !pending;

  pws_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .din(ack_n), .dout(ack_s)
  );

  pws_entry #(.HOLD(ENTRY_HOLD)) u_entry (
    .clk(clk), .rst_n(rst_n), .arm(arm), .elig(elig), .go(go)
  );

  pws_wake #(.NWAKE(NWAKE)) u_wake (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .open(open),
    .pending(pending), .accept(accept), .wake_ok(wake_ok)
  );

  pws_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .go(go), .elig(elig), .policy_en(policy_en),
    .batt_ok(batt_low_n), .ack_low(ack_low), .pending(pending),
    .state(state), .open(open), .warn_n(warn_n), .prim_off_n(prim_off_n)
  );
endmodule

module pws_deep_sleep_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] sleep_state,
  input logic       ac_present,
  input logic       batt_low_n,
  input logic       policy_en,
  input logic       batt_only,
  input logic       ack_low,
  input logic       warn_n,
  input logic       prim_off_n,
  input logic       wake_ok
);
  a_r4_prim_off_under_warn: assert property (@(posedge clk) disable iff (!rst_n)
    !prim_off_n |-> !warn_n);

  a_r4_prim_off_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prim_off_n) |-> $past(ack_low));

  a_r6_release_order: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_n) |-> (prim_off_n && $past(prim_off_n)));

  a_r2_entry_policy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(warn_n) |-> ($past(policy_en) && $past(sleep_state[1]) &&
                       ($past(!batt_only) || $past(!ac_present))));

  a_r8_battery_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!prim_off_n && !batt_low_n && policy_en) |=> !prim_off_n);

  a_r8_wake_needs_battery: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ok |-> $past(batt_low_n));

  a_r11_no_wake_unmatched: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ok |-> !($past(!warn_n) && $past(!ack_low)));

  a_r9_disabled_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!policy_en && warn_n) |=> (warn_n && prim_off_n));

  a_r9_disable_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (!policy_en && !prim_off_n) |=> prim_off_n);
endmodule

bind pws_deep_sleep_ctrl pws_deep_sleep_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_state(sleep_state), .ac_present(ac_present),
  .batt_low_n(batt_low_n), .policy_en(policy_en), .batt_only(batt_only),
  .ack_low(ack_low), .warn_n(warn_n), .prim_off_n(prim_off_n), .wake_ok(wake_ok)
);

// File: tb/pws_deep_sleep_ctrl_test.sv
module pws_deep_sleep_ctrl_test;
  localparam int NW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    sleep_state = 2'b00;
  logic          ac_present = 1'b1;
  logic          batt_low_n = 1'b1;
  logic          policy_en = 1'b0;
  logic          batt_only = 1'b0;
  logic          tie = 1'b0;
  logic          ack_drv = 1'b1;
  logic [NW-1:0] wake_req = '0;
  logic          ack_n;
  logic          warn_n, prim_off_n, wake_ok;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign ack_n = tie ? warn_n : ack_drv;

  pws_deep_sleep_ctrl #(.NWAKE(NW), .SYNC_STAGES(2), .ENTRY_HOLD(4)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_state(sleep_state), .ac_present(ac_present),
    .batt_low_n(batt_low_n), .policy_en(policy_en), .batt_only(batt_only),
    .ack_n(ack_n), .wake_req(wake_req), .warn_n(warn_n), .prim_off_n(prim_off_n),
    .wake_ok(wake_ok)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic set_elig(input logic [1:0] st, input logic bo, input logic ac);
    policy_en = 1'b1; sleep_state = st; batt_only = bo; ac_present = ac;
  endtask

  task automatic settle_idle();
    policy_en = 1'b0; sleep_state = 2'b00; wake_req = '0; batt_low_n = 1'b1;
    tick(8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset values
    tick(3);
    chk("R1 warn_n", warn_n, 1'b1);
    chk("R1 prim_off_n", prim_off_n, 1'b1);
    chk("R1 wake_ok", wake_ok, 1'b0);
    rst_n = 1'b1;
    tick(2);

    // R2/R3/R5: sweep of all eligibility inputs, acknowledge withheld
    for (int i = 0; i < 32; i++) begin
      logic expe;
      policy_en = i[4]; batt_only = i[3]; ac_present = i[2]; sleep_state = i[1:0];
      expe = i[4] & i[1] & (~i[3] | ~i[2]);
      tick(3);
      chk("R3 warn before hold", warn_n, 1'b1);
      tick(1);
      chk("R2 entry decision", warn_n, ~expe);
      chk("R4 no ack no prim_off", prim_off_n, 1'b1);
      policy_en = 1'b0;
      tick(4);
      chk("R5 abort warn high", warn_n, 1'b1);
      chk("R9 disabled prim_off", prim_off_n, 1'b1);
    end

    // R3: an ineligible cycle restarts the count
    set_elig(2'b11, 1'b0, 1'b1);
    tick(3);
    sleep_state = 2'b01;
    tick(1);
    sleep_state = 2'b11;
    tick(3);
    chk("R3 restart high", warn_n, 1'b1);
    tick(1);
    chk("R3 restart low", warn_n, 1'b0);
    settle_idle();

    // R4/R6/R7/R10: tied acknowledge, wake exit
    tie = 1'b1;
    set_elig(2'b11, 1'b1, 1'b0);
    tick(4);
    chk("R3 warn tied", warn_n, 1'b0);
    tick(2);
    chk("R4 prim_off waits sync", prim_off_n, 1'b1);
    tick(1);
    chk("R4 prim_off tied", prim_off_n, 1'b0);
    tick(3);
    chk("R4 deep held", prim_off_n, 1'b0);
    wake_req = 3'b010;
    tick(1);
    chk("R10 wake not yet", wake_ok, 1'b0);
    tick(1);
    chk("R10 wake strobe deep", wake_ok, 1'b1);
    chk("R6 prim_off released", prim_off_n, 1'b1);
    chk("R6 warn still low", warn_n, 1'b0);
    wake_req = '0; sleep_state = 2'b00;
    tick(1);
    chk("R6 warn released", warn_n, 1'b1);
    chk("R10 single pulse", wake_ok, 1'b0);
    wake_req = 3'b001;
    tick(1);
    chk("R7 wake held u1", wake_ok, 1'b0);
    tick(1);
    chk("R7 wake held u2", wake_ok, 1'b0);
    tick(1);
    chk("R7 wake held u3", wake_ok, 1'b0);
    tick(1);
    chk("R10 wake idle", wake_ok, 1'b1);
    settle_idle();

    // R11/R7: manual acknowledge latency
    tie = 1'b0; ack_drv = 1'b1;
    set_elig(2'b10, 1'b0, 1'b1);
    tick(4);
    chk("R2 warn manual", warn_n, 1'b0);
    wake_req = 3'b100;
    tick(5);
    chk("R11 wake parked", wake_ok, 1'b0);
    chk("R4 waiting ack", prim_off_n, 1'b1);
    ack_drv = 1'b0;
    tick(2);
    chk("R4 sync latency", prim_off_n, 1'b1);
    tick(1);
    chk("R4 prim_off manual", prim_off_n, 1'b0);
    tick(1);
    chk("R11 wake released", wake_ok, 1'b1);
    chk("R6 exit on wake", prim_off_n, 1'b1);
    wake_req = '0;
    tick(1);
    chk("R6 warn up manual", warn_n, 1'b1);
    tick(8);
    chk("R7 no entry before ack", warn_n, 1'b1);
    ack_drv = 1'b1;
    tick(6);
    chk("R7 idle then hold", warn_n, 1'b1);
    tick(1);
    chk("R7 reentry", warn_n, 1'b0);
    settle_idle();

    // R6: loss of eligibility exits without a wake
    tie = 1'b1;
    set_elig(2'b11, 1'b1, 1'b0);
    tick(7);
    chk("R4 deep again", prim_off_n, 1'b0);
    sleep_state = 2'b00;
    tick(1);
    chk("R6 elig exit prim", prim_off_n, 1'b1);
    chk("R6 elig exit no wake", wake_ok, 1'b0);
    tick(1);
    chk("R6 elig exit warn", warn_n, 1'b1);
    settle_idle();

    // R8: battery low blocks exit and wakes
    set_elig(2'b11, 1'b1, 1'b0);
    tick(7);
    chk("R8 deep", prim_off_n, 1'b0);
    batt_low_n = 1'b0; ac_present = 1'b1; wake_req = 3'b001;
    tick(6);
    chk("R8 held deep", prim_off_n, 1'b0);
    chk("R8 no wake", wake_ok, 1'b0);
    batt_low_n = 1'b1;
    tick(1);
    chk("R8 wake after battery", wake_ok, 1'b1);
    chk("R8 exit after battery", prim_off_n, 1'b1);
    settle_idle();

    // R9: policy clear forces exit under battery low
    set_elig(2'b10, 1'b0, 1'b0);
    tick(7);
    chk("R9 deep", prim_off_n, 1'b0);
    batt_low_n = 1'b0; policy_en = 1'b0;
    tick(1);
    chk("R9 forced prim", prim_off_n, 1'b1);
    tick(1);
    chk("R9 forced warn", warn_n, 1'b1);
    tick(6);
    chk("R9 stays out", warn_n, 1'b1);
    chk("R9 no wake", wake_ok, 1'b0);
    settle_idle();

    // R12: pending wake in idle restarts the count
    set_elig(2'b10, 1'b0, 1'b1);
    wake_req = 3'b010;
    tick(2);
    chk("R10 idle wake strobe", wake_ok, 1'b1);
    chk("R12 no entry", warn_n, 1'b1);
    tick(2);
    chk("R12 count restarted", warn_n, 1'b1);
    tick(1);
    chk("R12 still counting", warn_n, 1'b1);
    tick(1);
    chk("R12 entry late", warn_n, 1'b0);
    settle_idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule